// File: doc/BRIEF.md
# Sixteen-Bit YA Arithmetic Extension Unit

This unit executes the extended accumulator operations of an 8-bit processor core. Two 8-bit registers, Y and A, are treated as one 16-bit value. Y holds the low byte and A holds the high byte. The unit receives an operation code, the current A, Y and S registers, the flag bits and an immediate byte. On each clock edge it registers the updated A, Y, S and flags, so the results appear one cycle after the inputs are presented.

Six operations are supported:
- an unsigned 8x8 multiply with a 16-bit product;
- sign extension of Y into the pair;
- a 16-bit zero and sign test;
- an add of an immediate to Y with carry, setting the flags the way an add-with-carry does;
- an exchange of the carry and task flags;
- an add of A to the stack pointer.

An operation changes only the registers and flags that its definition names. Everything else passes through unchanged.

Top module: `ya_ext_unit`

## Requirements
- R1: While `rst_n` is low, every output register reads zero on the next clock edge.
- R2: Operation code 1 (multiply) writes the unsigned product of A and Y to the pair. The high byte goes to `a_o` and the low byte to `y_o`.
- R3: Operation code 2 (sign) sets `a_o` to 0xFF when bit 7 of Y is 1 and to 0x00 otherwise, and leaves `y_o` equal to Y. N is set from bit 15 of the pair, and Z is set only when the whole 16-bit result is zero.
- R4: Operation code 3 (test) leaves A and Y unchanged. N is set from bit 7 of A, and Z is set only when both A and Y are zero.
- R5: Operation code 4 (add-to-Y) writes Y + imm + C (mod 256) to `y_o` and sets C to the carry out of bit 7. N is set from bit 7 of the sum, and Z is set when the sum is zero.
- R6: Operation code 4 sets V when Y and imm have the same sign and the sign of the sum differs from theirs, and clears V otherwise.
- R7: Operation code 5 swaps C and T and leaves N, V and Z unchanged.
- R8: Operation code 6 writes S + A (mod 256) to `s_o`.
- R9: The flag vector is laid out as bit 4 N, bit 3 V, bit 2 T, bit 1 Z, bit 0 C. Operation codes 0, 1, 6 and 7 pass all flags through unchanged. Codes 2 and 3 alter only N and Z, and code 4 never alters T.
- R10: Every operation other than code 6 passes S through unchanged.
- R11: Operation codes 0 and 7 pass A, Y, S and the flags through unchanged.
- R12: Every output reflects the inputs sampled at the immediately preceding clock edge, with a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code |
| a_i | input | 8 | Current A (high byte of pair) |
| y_i | input | 8 | Current Y (low byte of pair) |
| s_i | input | 8 | Current stack pointer |
| flags_i | input | 5 | Current flags {N,V,T,Z,C} |
| imm_i | input | 8 | Immediate for add-to-Y |
| a_o | output | 8 | Updated A |
| y_o | output | 8 | Updated Y |
| s_o | output | 8 | Updated stack pointer |
| flags_o | output | 5 | Updated flags {N,V,T,Z,C} |

## Verification
In the add-to-Y operation, the carry out and the signed overflow are two separate judgements, and both can be set in the same cycle.

The bench provokes this in several ways:
- Adding 0x80 to 0x80 sets both flags and also produces a zero sum.
- Adding 0x7F to 0x01 sets overflow without carry.
- Adding 0xFF to 0x00 with carry in sets carry without overflow.

A behavioural model in the bench compares each of these cases, flag by flag, against the registered outputs one cycle later. Random operands then mix the two conditions freely.

// File: rtl/ya_pkg.sv
// Package: shared operation codes and flag bit positions for the YA unit.
package ya_pkg;
    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_MUL = 3'd1,
        OP_SGN = 3'd2,
        OP_TST = 3'd3,
        OP_ADY = 3'd4,
        OP_XCT = 3'd5,
        OP_AAS = 3'd6,
        OP_RSV = 3'd7
    } ya_op_e;

    localparam int unsigned FLAG_W = 5;
    localparam int unsigned FN = 4;
    localparam int unsigned FV = 3;
    localparam int unsigned FT = 2;
    localparam int unsigned FZ = 1;
    localparam int unsigned FC = 0;
endpackage

// File: rtl/ya_mul.sv
// Module: unsigned W x W multiplier built from shifted partial products.
// Assumes: purely combinational; the product is 2*W bits wide.
module ya_mul #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   k,
    output logic [2*W-1:0] prod
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] pp [W];

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_pp
            // one partial product per multiplier bit
            assign pp[gi] = k[gi] ? (PW'(x) << gi) : '0;
        end
    endgenerate

    // sum the partial products
    always_comb begin
        prod = '0;
        for (int i = 0; i < W; i++) begin
            prod = prod + pp[i];
        end
    end
endmodule

// File: rtl/ya_add.sv
// Module: W-bit add with carry in, giving sum, carry, overflow, sign and zero.
// Assumes: two's-complement overflow rule; combinational.
module ya_add #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] k,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co,
    output logic         ovf,
    output logic         neg,
    output logic         zero
);
    logic [W:0] wide;

    // form the sum and derive its flags
    always_comb begin
        wide = {1'b0, x} + {1'b0, k} + {{W{1'b0}}, ci};
        sum  = wide[W-1:0];
        co   = wide[W];
        ovf  = (x[W-1] == k[W-1]) && (wide[W-1] != x[W-1]);
        neg  = wide[W-1];
        zero = (wide[W-1:0] == '0);
    end
endmodule

// File: rtl/ya_nz.sv
// Module: sign and zero detection over a 2*W bit pair value.
// Assumes: sign is the top bit; zero needs every bit clear.
module ya_nz #(
    parameter int unsigned W = 8
) (
    input  logic [2*W-1:0] pair,
    output logic           neg,
    output logic           zero
);
    // detect sign and zero of the pair
    always_comb begin
        neg  = pair[2*W-1];
        zero = (pair == '0);
    end
endmodule

// File: rtl/ya_ext_unit.sv
// Module: YA extension execution unit. Selects one of the extended operations,
//         computes next A, Y, S and flags, and registers them.
// Assumes: pair is {A (high), Y (low)}; flags are {N,V,T,Z,C}; one-cycle latency;
//          synchronous active-low reset clears all outputs.
module ya_ext_unit #(
    parameter int unsigned W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                op_i,
    input  logic [W-1:0]              a_i,
    input  logic [W-1:0]              y_i,
    input  logic [W-1:0]              s_i,
    input  logic [ya_pkg::FLAG_W-1:0] flags_i,
    input  logic [W-1:0]              imm_i,
    output logic [W-1:0]              a_o,
    output logic [W-1:0]              y_o,
    output logic [W-1:0]              s_o,
    output logic [ya_pkg::FLAG_W-1:0] flags_o
);
    import ya_pkg::*;

    localparam int unsigned PW = 2 * W;

    ya_op_e              op;
    logic [PW-1:0]       prod;
    logic [PW-1:0]       nz_src;
    logic                nz_neg, nz_zero;
    logic [W-1:0]        add_sum;
    logic                add_co, add_ovf, add_neg, add_zero;
    logic [W-1:0]        a_n, y_n, s_n;
    logic [FLAG_W-1:0]   f_n;

    assign op = ya_op_e'(op_i);

    ya_mul #(.W(W)) u_mul (
        .x    (a_i),
        .k    (y_i),
        .prod (prod)
    );

    ya_add #(.W(W)) u_add (
        .x    (y_i),
        .k    (imm_i),
        .ci   (flags_i[FC]),
        .sum  (add_sum),
        .co   (add_co),
        .ovf  (add_ovf),
        .neg  (add_neg),
        .zero (add_zero)
    );

    // choose the pair that feeds sign/zero detection
    always_comb begin
        if (op == OP_SGN) begin
            nz_src = {{W{y_i[W-1]}}, y_i};
        end else begin
            nz_src = {a_i, y_i};
        end
    end

    ya_nz #(.W(W)) u_nz (
        .pair (nz_src),
        .neg  (nz_neg),
        .zero (nz_zero)
    );

    // next-state selection per operation
    always_comb begin
        a_n = a_i;
        y_n = y_i;
        s_n = s_i;
        f_n = flags_i;
        case (op)
            OP_MUL: begin
                a_n = prod[PW-1:W];
                y_n = prod[W-1:0];
            end
            OP_SGN: begin
                a_n     = {W{y_i[W-1]}};
                f_n[FN] = nz_neg;
                f_n[FZ] = nz_zero;
            end
            OP_TST: begin
                f_n[FN] = nz_neg;
                f_n[FZ] = nz_zero;
            end
            OP_ADY: begin
                y_n     = add_sum;
                f_n[FN] = add_neg;
                f_n[FV] = add_ovf;
                f_n[FZ] = add_zero;
                f_n[FC] = add_co;
            end
            OP_XCT: begin
                f_n[FC] = flags_i[FT];
                f_n[FT] = flags_i[FC];
            end
            OP_AAS: begin
                s_n = s_i + a_i;
            end
            default: begin
            end
        endcase
    end

    // register results; synchronous reset clears them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_o     <= '0;
            y_o     <= '0;
            s_o     <= '0;
            flags_o <= '0;
        end else begin
            a_o     <= a_n;
            y_o     <= y_n;
            s_o     <= s_n;
            flags_o <= f_n;
        end
    end
endmodule

// File: rtl/ya_ext_checker.sv
// Module: property checker for ya_ext_unit, attached by bind.
// Assumes: outputs compare against inputs sampled one edge earlier; armed
//          only after one clock with reset released.
module ya_ext_checker #(
    parameter int unsigned W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [2:0]                op_i,
    input logic [W-1:0]              a_i,
    input logic [W-1:0]              y_i,
    input logic [W-1:0]              s_i,
    input logic [ya_pkg::FLAG_W-1:0] flags_i,
    input logic [W-1:0]              imm_i,
    input logic [W-1:0]              a_o,
    input logic [W-1:0]              y_o,
    input logic [W-1:0]              s_o,
    input logic [ya_pkg::FLAG_W-1:0] flags_o
);
    import ya_pkg::*;

    logic armed;

    // armed once a full cycle has run out of reset
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (a_o == '0 && y_o == '0 && s_o == '0 && flags_o == '0));

    p_mul_prod_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_MUL) |->
        ({a_o, y_o} == ((2*W)'($past(a_i)) * (2*W)'($past(y_i)))));

    p_sgn_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_SGN) |->
        (a_o == {W{$past(y_i[W-1])}} && y_o == $past(y_i) &&
         flags_o[FN] == $past(y_i[W-1]) && flags_o[FZ] == ($past(y_i) == '0)));

    p_tst_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_TST) |->
        (a_o == $past(a_i) && y_o == $past(y_i) && flags_o[FN] == $past(a_i[W-1]) &&
         flags_o[FZ] == ($past(a_i) == '0 && $past(y_i) == '0)));

    p_ady_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_ADY) |->
        ({flags_o[FC], y_o} == ((W+1)'($past(y_i)) + (W+1)'($past(imm_i)) +
                                 (W+1)'($past(flags_i[FC])))));

    p_ady_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_ADY) |->
        (flags_o[FV] == ($past(y_i[W-1]) == $past(imm_i[W-1]) &&
                         y_o[W-1] != $past(y_i[W-1]))));

    p_xct_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_XCT) |->
        (flags_o[FC] == $past(flags_i[FT]) && flags_o[FT] == $past(flags_i[FC]) &&
         flags_o[FN] == $past(flags_i[FN]) && flags_o[FV] == $past(flags_i[FV]) &&
         flags_o[FZ] == $past(flags_i[FZ])));

    p_aas_add_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_AAS) |->
        (s_o == W'($past(s_i) + $past(a_i))));

    p_flags_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(op_i) == OP_NOP || $past(op_i) == OP_MUL ||
                   $past(op_i) == OP_AAS || $past(op_i) == OP_RSV)) |->
        (flags_o == $past(flags_i)));

    p_t_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) != OP_XCT) |-> (flags_o[FT] == $past(flags_i[FT])));

    p_s_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) != OP_AAS) |-> (s_o == $past(s_i)));

    p_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(op_i) == OP_NOP || $past(op_i) == OP_RSV)) |->
        (a_o == $past(a_i) && y_o == $past(y_i)));
endmodule

bind ya_ext_unit ya_ext_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .a_i     (a_i),
    .y_i     (y_i),
    .s_i     (s_i),
    .flags_i (flags_i),
    .imm_i   (imm_i),
    .a_o     (a_o),
    .y_o     (y_o),
    .s_o     (s_o),
    .flags_o (flags_o)
);

// File: tb/sim_ya_ext_unit.sv
module sim_ya_ext_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_i = '0;
    logic [7:0] a_i = '0, y_i = '0, s_i = '0, imm_i = '0;
    logic [4:0] flags_i = '0;
    logic [7:0] a_o, y_o, s_o;
    logic [4:0] flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ya_ext_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .y_i(y_i),
        .s_i(s_i), .flags_i(flags_i), .imm_i(imm_i),
        .a_o(a_o), .y_o(y_o), .s_o(s_o), .flags_o(flags_o)
    );

    // behavioural reference: returns {a, y, s, flags}
    function automatic logic [28:0] model(int op, int a, int y, int s, logic [4:0] f, int imm);
        int na = a, ny = y, ns = s, r;
        logic [4:0] nf = f;
        case (op)
            1: begin r = a * y; ny = r % 256; na = r / 256; end
            2: begin na = (y >= 128) ? 255 : 0; nf[4] = (y >= 128); nf[1] = (y == 0); end
            3: begin nf[4] = (a >= 128); nf[1] = (a == 0 && y == 0); end
            4: begin
                r = y + imm + int'(f[0]);
                ny = r % 256;
                nf[0] = (r > 255);
                nf[4] = (ny >= 128);
                nf[1] = (ny == 0);
                nf[3] = ((y >= 128) == (imm >= 128)) && ((ny >= 128) != (y >= 128));
            end
            5: begin nf[0] = f[2]; nf[2] = f[0]; end
            6: ns = (s + a) % 256;
            default: ;
        endcase
        return {8'(na), 8'(ny), 8'(ns), nf};
    endfunction

    task automatic check(bit ok, string req, logic [28:0] act, logic [28:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one operation, compare on the next cycle
    task automatic step(int op, int a, int y, int s, logic [4:0] f, int imm);
        logic [28:0] exp, act;
        string tag;
        op_i = 3'(op); a_i = 8'(a); y_i = 8'(y); s_i = 8'(s); flags_i = f; imm_i = 8'(imm);
        exp = model(op, a, y, s, f, imm);
        @(negedge clk);
        act = {a_o, y_o, s_o, flags_o};
        case (op)
            1: tag = "R2 mul";   2: tag = "R3 sgn"; 3: tag = "R4 tst";
            4: tag = "R5/R6 ady"; 5: tag = "R7 xct"; 6: tag = "R8 aas";
            default: tag = "R11 pass";
        endcase
        // R12: result must appear exactly one cycle after the inputs
        check(act == exp, {tag, " R12"}, act, exp);
        if (op == 0 || op == 1 || op == 6 || op == 7)
            check(flags_o == exp[4:0], "R9 flags kept", 29'(flags_o), 29'(exp[4:0]));
        if (op != 6)
            check(s_o == exp[12:5], "R10 s kept", 29'(s_o), 29'(exp[12:5]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({a_o, y_o, s_o, flags_o} == '0, "R1 reset", {a_o, y_o, s_o, flags_o}, '0);
        rst_n = 1'b1;
        step(1, 8'hFF, 8'hFF, 8'h10, 5'b10101, 0);
        step(1, 8'h00, 8'h37, 8'h10, 5'b00000, 0);
        step(1, 8'h12, 8'h10, 8'h22, 5'b01010, 0);
        step(2, 8'h55, 8'h80, 8'h01, 5'b01111, 0);
        step(2, 8'hAA, 8'h00, 8'h01, 5'b10000, 0);
        step(2, 8'hAA, 8'h7F, 8'h01, 5'b11110, 0);
        step(3, 8'h00, 8'h00, 8'h02, 5'b10000, 0);
        step(3, 8'h00, 8'h01, 8'h02, 5'b00010, 0);
        step(3, 8'h80, 8'h00, 8'h02, 5'b00110, 0);
        step(4, 0, 8'h7F, 8'h03, 5'b00000, 8'h01);  // R6 overflow, no carry
        step(4, 0, 8'h80, 8'h03, 5'b00000, 8'h80);  // R6 carry and overflow together
        step(4, 0, 8'hFF, 8'h03, 5'b00101, 8'h00);  // R5 carry in wraps to zero
        step(4, 0, 8'h10, 8'h03, 5'b01001, 8'h20);
        step(5, 1, 2, 3, 5'b00001, 0);              // R7 C=1 T=0
        step(5, 1, 2, 3, 5'b11110, 0);
        step(5, 1, 2, 3, 5'b10101, 0);
        step(6, 8'h20, 1, 8'hF0, 5'b11011, 0);      // R8 wrap
        step(6, 8'h01, 1, 8'h7F, 5'b00000, 0);
        step(0, 8'h9A, 8'hBC, 8'hDE, 5'b10110, 8'h11);
        step(7, 8'h01, 8'h02, 8'h03, 5'b01001, 8'hFF);
        for (int i = 0; i < 400; i++) begin
            step(int'($urandom_range(7)), int'($urandom_range(255)), int'($urandom_range(255)),
                 int'($urandom_range(255)), 5'($urandom), int'($urandom_range(255)));
        end
        // R1 again: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check({a_o, y_o, s_o, flags_o} == '0, "R1 reset", {a_o, y_o, s_o, flags_o}, '0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule